// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single count-down timer sitting on a simple word-addressed register bus. Software writes a start value and a control word. The counter then steps down once per prescaled tick, and a level interrupt is raised when it runs out. The tick is the core clock divided by 1, 16 or 256. On expiry the counter does one of three things:
- In one-shot mode it parks at zero.
- In free-running mode it wraps to the all-ones value for the selected width.
- In periodic mode it refills from a stored reload value.

A second address writes that reload value without touching the count in progress. This lets software change the next period smoothly.

Reads are combinational from the current register state. Writes take effect at the clock edge on which `bus_sel` and `bus_wr` are both high. The interrupt output is the latched expiry flag gated by the interrupt-enable bit.

Top module: `countdown_timer`

## Requirements
- R1: After reset the control word reads 0x20 (only interrupt enable set), the count reads 0xFFFFFFFF, the reload value reads 0, the raw flag reads 0 and `irq` is low.
- R2: Word addresses decode as follows: 0 start/reload value, 1 count, 2 control (8 bits, zero-extended), 3 flag clear, 4 raw flag (bit 0), 5 masked flag (bit 0), 6 reload value only. Reads of address 0 and of address 6 both return the reload value. Writes to address 1 are ignored.
- R3: A write to address 0 sets both the reload value and the count, and it wins over a tick in the same cycle. It also restarts the prescaler, so after a write with divide-by-1 the count is one lower after the next edge.
- R4: A write to address 6 changes only the reload value. The count in progress keeps stepping, and the new value is used at the next periodic refill.
- R5: With control bit 0 set (one-shot), expiry leaves the count at 0. Further ticks keep it at 0 and never set the raw flag again.
- R6: With bits 0 and 6 clear (free-running), expiry loads 0x0000FFFF if bit 1 is clear (16-bit) or 0xFFFFFFFF if bit 1 is set (32-bit).
- R7: With bit 6 set and bit 0 clear (periodic), expiry loads the stored reload value.
- R8: Control bits 3:2 select the tick. 00 ticks every cycle, 01 every 16 cycles and 10 or 11 every 256 cycles. The prescaler is held at its start while bit 7 (enable) is clear, so the first decrement comes exactly one tick period after the enabling edge.
- R9: While bit 7 is clear the count holds. Writing the control word does not change the count, and a timer that is paused and re-enabled carries on from the held value.
- R10: In 16-bit mode only bits 15:0 decrement and take part in the expiry test. Bits 31:16 are left as they are until a wrap or reload.
- R11: The raw flag is set on the tick that takes the counted bits from 1 to 0. In repeating modes a tick taken while they are already 0 also sets it. A write of any data to address 3 clears it, but an expiry in the same cycle wins.
- R12: The masked flag (address 5) and `irq` equal the raw flag ANDed with control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt, raw flag gated by enable |

## Verification
**Register writes.** A write's effect can be read back half a cycle after its edge, because read data is combinational from the registers.

**First decrement.** After an enabling control write, the first decrement lands on edge N, where N is the divide ratio (1, 16 or 256).

**Expiry.** Starting from a value V with divide-by-1, expiry and the raw flag land on edge V after the enable.

**How the checks keep to this timing.** Every bench step starts half a cycle after an edge. Each check is queued with its expected value after an exact count of edges, and the monitor samples it 1 ns later, well away from any clock edge.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  localparam int PRE_W = 8;

  localparam logic [2:0] A_START  = 3'd0;
  localparam logic [2:0] A_COUNT  = 3'd1;
  localparam logic [2:0] A_CTRL   = 3'd2;
  localparam logic [2:0] A_CLEAR  = 3'd3;
  localparam logic [2:0] A_RAW    = 3'd4;
  localparam logic [2:0] A_MASKED = 3'd5;
  localparam logic [2:0] A_RELOAD = 3'd6;

  typedef struct packed {
    logic       run;
    logic       repeat_ld;
    logic       irq_en;
    logic       spare;
    logic [1:0] div_sel;
    logic       wide;
    logic       single;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = 8'h20;

  function automatic logic [PRE_W-1:0] div_last(input logic [1:0] sel);
    case (sel)
      2'b00:   div_last = PRE_W'(0);
      2'b01:   div_last = PRE_W'(15);
      default: div_last = PRE_W'(255);
    endcase
  endfunction

endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int PW = cdt_pkg::PRE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [PW-1:0] last,
  output logic          tick
);
  logic [PW-1:0] phase;

  // >= so that shrinking the ratio mid-count still ticks promptly
  assign tick = run && (phase >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)                     phase <= '0;
    else if (!run || restart || tick) phase <= '0;
    else                            phase <= phase + 1'b1;
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start_wr,
  input  logic [CW-1:0] start_val,
  input  logic [CW-1:0] reload_val,
  input  logic          single,
  input  logic          repeat_ld,
  input  logic          wide,
  output logic [CW-1:0] count,
  output logic [CW-1:0] counted,
  output logic          expire,
  output logic          parked
);
  localparam int HW = CW - SW;

  function automatic logic [CW-1:0] active_bits(input logic [CW-1:0] v, input logic w);
    active_bits = w ? v : {{HW{1'b0}}, v[SW-1:0]};
  endfunction

  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] v, input logic w);
    logic [SW-1:0] lo;
    lo = v[SW-1:0] - 1'b1;
    step_down = w ? (v - 1'b1) : {v[CW-1:SW], lo};
  endfunction

  function automatic logic [CW-1:0] wrap_value(input logic w);
    wrap_value = w ? {CW{1'b1}} : {{HW{1'b0}}, {SW{1'b1}}};
  endfunction

  logic [CW-1:0] next_after_expiry;

  assign counted = active_bits(count, wide);
  assign parked  = single && (counted == '0);
  assign expire  = tick && !start_wr && !parked && (counted <= CW'(1));

  always_comb begin
    if (single)         next_after_expiry = '0;
    else if (repeat_ld) next_after_expiry = reload_val;
    else                next_after_expiry = wrap_value(wide);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  count <= '1;
    else if (start_wr)           count <= start_val;
    else if (expire)             count <= next_after_expiry;
    else if (tick && !parked)    count <= step_down(count, wide);
  end
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer #(
  parameter int DW = 32,
  parameter int SHORT_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  import cdt_pkg::*;

  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t         ctrl_q;
  logic [DW-1:0] reload_q;
  logic          raw_q;
  logic [DW-1:0] count;
  logic [DW-1:0] counted;
  logic          tick;
  logic          expire;
  logic          parked;

  logic wr_any, wr_start, wr_ctrl, wr_clear, wr_reload;
  assign wr_any    = bus_sel && bus_wr;
  assign wr_start  = wr_any && (bus_addr == A_START);
  assign wr_ctrl   = wr_any && (bus_addr == A_CTRL);
  assign wr_clear  = wr_any && (bus_addr == A_CLEAR);
  assign wr_reload = wr_any && (bus_addr == A_RELOAD);

  logic masked;
  assign masked = raw_q && ctrl_q.irq_en;
  assign irq    = masked;

  cdt_prescaler #(.PW(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .restart (wr_start),
    .last    (div_last(ctrl_q.div_sel)),
    .tick    (tick)
  );

  cdt_counter #(.CW(DW), .SW(SHORT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .start_wr   (wr_start),
    .start_val  (bus_wdata),
    .reload_val (reload_q),
    .single     (ctrl_q.single),
    .repeat_ld  (ctrl_q.repeat_ld),
    .wide       (ctrl_q.wide),
    .count      (count),
    .counted    (counted),
    .expire     (expire),
    .parked     (parked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RESET;
      reload_q <= '0;
      raw_q    <= 1'b0;
    end else begin
      if (wr_ctrl)               ctrl_q   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_start || wr_reload) reload_q <= bus_wdata;
      if (expire)                raw_q    <= 1'b1;
      else if (wr_clear)         raw_q    <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_START, A_RELOAD: bus_rdata = reload_q;
      A_COUNT:           bus_rdata = count;
      A_CTRL:            bus_rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
      A_RAW:             bus_rdata = {{(DW-1){1'b0}}, raw_q};
      A_MASKED:          bus_rdata = {{(DW-1){1'b0}}, masked};
      default:           bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          single,
  input logic          repeat_ld,
  input logic          irq,
  input logic          raw_q,
  input logic          tick,
  input logic          expire,
  input logic          wr_start,
  input logic          wr_clear,
  input logic [DW-1:0] count,
  input logic [DW-1:0] counted,
  input logic [DW-1:0] reload_q
);
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_start) |=> $stable(count)); // R9

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run); // R8

  AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (single && counted == '0 && !wr_start) |=> (count == $past(count))); // R5

  AST_PERIODIC_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && repeat_ld && !single) |=> (count == $past(reload_q))); // R7

  AST_RAW_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> $past(expire)); // R11

  AST_RAW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clear && !expire) |=> !raw_q); // R11

  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> raw_q); // R12
endmodule

bind countdown_timer cdt_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (ctrl_q.run),
  .single    (ctrl_q.single),
  .repeat_ld (ctrl_q.repeat_ld),
  .irq       (irq),
  .raw_q     (raw_q),
  .tick      (tick),
  .expire    (expire),
  .wr_start  (wr_start),
  .wr_clear  (wr_clear),
  .count     (count),
  .counted   (counted),
  .reload_q  (reload_q)
);

// File: tb/countdown_timer_bench.sv
module countdown_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          pin;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  countdown_timer u_countdown_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: pops each expected item and compares 1 ns after it was queued
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      wait (sb_q.size() > 0);
      #1;
      it = sb_q.pop_front();
      act = it.pin ? {31'd0, irq} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  // all tasks start and end half a cycle after a rising edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.pin = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    it.pin = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(3'd2, 32'h20, "R1 ctrl");
    chk(3'd1, 32'hFFFF_FFFF, "R1 count");
    chk(3'd0, 32'h0, "R1 reload");
    chk(3'd4, 32'h0, "R1 raw");
    chk_irq(1'b0, "R1 irq");
    // R3 start write while stopped, R9 hold, R2 decode
    wr(3'd0, 32'd5);
    chk(3'd1, 32'd5, "R3 count");
    chk(3'd0, 32'd5, "R3 reload");
    cycles(3);
    chk(3'd1, 32'd5, "R9 held");
    wr(3'd1, 32'h1234);
    chk(3'd1, 32'd5, "R2 count write ignored");
    chk(3'd6, 32'd5, "R2 addr6 read");
    // R5 one-shot, 32-bit, div1, irq enabled
    wr(3'd2, 32'hA3);
    chk(3'd2, 32'hA3, "R2 ctrl readback");
    cycles(4);
    chk(3'd1, 32'd1, "R11 before expiry");
    chk(3'd4, 32'd0, "R11 raw before");
    cycles(1);
    chk(3'd1, 32'd0, "R5 parked");
    chk(3'd4, 32'd1, "R11 raw set");
    chk(3'd5, 32'd1, "R12 masked");
    chk_irq(1'b1, "R12 irq");
    wr(3'd3, 32'd0);
    chk(3'd4, 32'd0, "R11 clear");
    cycles(10);
    chk(3'd4, 32'd0, "R5 no re-raise");
    chk(3'd1, 32'd0, "R5 stays zero");
    // R7 periodic, R4 background reload
    wr(3'd2, 32'h00);
    wr(3'd0, 32'd3);
    wr(3'd2, 32'hE2);
    cycles(3);
    chk(3'd1, 32'd3, "R7 refill");
    chk(3'd4, 32'd1, "R7 raw");
    wr(3'd6, 32'd7);
    chk(3'd1, 32'd2, "R4 count unaffected");
    chk(3'd0, 32'd7, "R4 reload updated");
    cycles(2);
    chk(3'd1, 32'd7, "R4 new period");
    // R12 masking
    wr(3'd2, 32'h42);
    chk(3'd4, 32'd1, "R12 raw kept");
    chk(3'd5, 32'd0, "R12 masked off");
    chk_irq(1'b0, "R12 irq off");
    wr(3'd3, 32'd0);
    // R6 free-running 16-bit
    wr(3'd0, 32'd2);
    wr(3'd2, 32'hA0);
    cycles(2);
    chk(3'd1, 32'h0000_FFFF, "R6 wrap16");
    chk(3'd4, 32'd1, "R6 raw16");
    // R6 free-running 32-bit
    wr(3'd2, 32'h00); wr(3'd3, 32'd0); wr(3'd0, 32'd1);
    wr(3'd2, 32'h82);
    cycles(1);
    chk(3'd1, 32'hFFFF_FFFF, "R6 wrap32");
    chk(3'd4, 32'd1, "R6 raw32");
    chk_irq(1'b0, "R12 irq masked");
    // R10 16-bit upper bits untouched
    wr(3'd2, 32'h00); wr(3'd3, 32'd0); wr(3'd0, 32'h0005_0002);
    wr(3'd2, 32'h80);
    cycles(1);
    chk(3'd1, 32'h0005_0001, "R10 low step");
    chk(3'd4, 32'd0, "R10 no early expiry");
    cycles(1);
    chk(3'd4, 32'd1, "R10 low zero detect");
    chk(3'd1, 32'h0000_FFFF, "R10 wrap");
    // R8 divide by 16
    wr(3'd2, 32'h00); wr(3'd3, 32'd0); wr(3'd0, 32'd2);
    wr(3'd2, 32'hC4);
    cycles(15);
    chk(3'd1, 32'd2, "R8 div16 not yet");
    cycles(1);
    chk(3'd1, 32'd1, "R8 div16 first step");
    cycles(15);
    chk(3'd4, 32'd0, "R8 div16 raw not yet");
    cycles(1);
    chk(3'd4, 32'd1, "R8 div16 expiry");
    chk(3'd1, 32'd2, "R8 div16 refill");
    // R8 divide by 256, codes 10 and 11
    for (int k = 0; k < 2; k++) begin
      wr(3'd2, 32'h00); wr(3'd3, 32'd0); wr(3'd0, 32'd1);
      wr(3'd2, (k == 0) ? 32'h8A : 32'h8E);
      cycles(255);
      chk(3'd1, 32'd1, "R8 div256 not yet");
      cycles(1);
      chk(3'd4, 32'd1, "R8 div256 expiry");
      chk(3'd1, 32'hFFFF_FFFF, "R8 div256 wrap");
    end
    // R9 pause and resume keep the count
    wr(3'd2, 32'h00); wr(3'd3, 32'd0); wr(3'd0, 32'd10);
    wr(3'd2, 32'hA2);
    cycles(3);
    chk(3'd1, 32'd7, "R9 running");
    wr(3'd2, 32'h22);
    chk(3'd1, 32'd6, "R9 count kept on ctrl write");
    cycles(5);
    chk(3'd1, 32'd6, "R9 paused");
    wr(3'd2, 32'hA2);
    chk(3'd1, 32'd6, "R9 resume edge");
    cycles(2);
    chk(3'd1, 32'd4, "R9 resumed");
    // R3 start write while running restarts
    wr(3'd0, 32'd9);
    chk(3'd1, 32'd9, "R3 restart");
    cycles(1);
    chk(3'd1, 32'd8, "R3 next step");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule